// File: doc/BRIEF.md
# Coprocessor Branch Resolver with Stage Counter

This block works out the next program counter of a small 16-bit coprocessor whose program counter is an 11-bit word index. It handles three branch forms. An absolute jump takes its target from a register or from an immediate. A relative branch compares R0 against a threshold. A relative branch compares an 8-bit stage counter against a threshold. The block also holds that stage counter and carries out the clear, add and subtract operations on it. The instruction decoder presents one operation per cycle with `opValid`, along with its fields, the current PC, R0, the register target and the zero and overflow flags of the last ALU operation. The fetch unit takes `nextPc` and `taken` on the following cycle.

Register targets are already word indices. Immediate targets are byte addresses, so the block drops their two low bits. Relative steps are signed byte distances from the current instruction. The block divides them by four, and the sum wraps within the 2048-word space. Each branch form has a small native set of conditions. The assembler builds the other conditions from two consecutive branch operations, and the block evaluates each of those operations on its own.

Top module: `branch_unit`

## Requirements
- R1: While `rstN` is low, and at the first edge after it goes low, `stageCnt` is 0, `taken` is 0 and `nextPc` is 0.
- R2: Counter operations take effect at the next clock edge. `opKind` 4 clears the counter, 5 adds `cntImm`, and 6 subtracts `cntImm`. The arithmetic wraps modulo 256.
- R3: `opKind` 0 is an absolute jump to a register target. When taken, `nextPc` is `regTarget[10:0]`, and the upper target bits are ignored.
- R4: `opKind` 1 is an absolute jump to an immediate byte address. When taken, `nextPc` is `immAddr[12:2]`.
- R5: For the absolute jumps, the condition is set by `opCond`. 0 means always taken, 1 means taken when `aluZero` is 1, 2 means taken when `aluOverflow` is 1, and any other value means never taken.
- R6: `opKind` 2 is the R0-relative branch, with an unsigned 16-bit compare of `r0Val` against `threshold`. `opCond` 0 takes the branch on equal, 1 on less-than and 2 on greater-than, and any other value never takes it.
- R7: `opKind` 3 is the counter-relative branch, with an unsigned compare of `stageCnt` against `threshold[7:0]`. `opCond` 0 takes the branch on less-than, 1 on less-or-equal and 2 on greater-or-equal, and any other value never takes it.
- R8: A taken relative branch gives `nextPc = curPc + (relStep >>> 2)` modulo 2048, where `relStep` is a signed 14-bit byte distance.
- R9: An operation that is not taken gives `taken` 0 and `nextPc = curPc + 1` modulo 2048. This covers counter operations and `opKind` 7, which leaves the counter unchanged.
- R10: Outputs change only at the edge after an operation is presented. A cycle with `opValid` low drives `taken` to 0 and holds `nextPc` and `stageCnt`.
- R11: A composite condition built from two consecutive operations gives the intended combined result. Examples are counter-equal (skip on less-than, then branch on less-or-equal) and R0 greater-or-equal (equal, then greater-than).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | An operation is presented this cycle |
| opKind | input | 3 | Operation code (see R2 to R9) |
| opCond | input | 3 | Condition selector for branches |
| immAddr | input | 13 | Immediate absolute target in bytes |
| relStep | input | 14 | Signed relative step in bytes |
| threshold | input | 16 | Compare threshold (counter uses low 8 bits) |
| cntImm | input | 8 | Counter add/subtract amount |
| curPc | input | 11 | Word index of the current instruction |
| r0Val | input | 16 | Value of register R0 |
| regTarget | input | 16 | Register-held target in words |
| aluZero | input | 1 | Last ALU result was zero |
| aluOverflow | input | 1 | Last ALU operation overflowed |
| nextPc | output | 11 | Resolved next program counter |
| taken | output | 1 | The resolved operation was a taken branch |
| stageCnt | output | 8 | Current stage counter value |

## Verification
The hardest state to reach from the ports is a counter-relative branch decided right at the threshold boundary, or right after the counter has wrapped. The counter can only be loaded through sequences of clear, add and subtract operations. The stimulus therefore builds each counter value with such a sequence, including subtractions that wrap below zero. It then issues the less-than, less-or-equal and greater-or-equal forms on values just below, at and above the threshold. The two-operation composites are driven in the order the assembler emits them, and the second operation is issued only when the first falls through.

// File: rtl/branch_pkg.sv
package branch_pkg;

  typedef enum logic [2:0] {
    OP_JREG = 3'd0,
    OP_JIMM = 3'd1,
    OP_JR0  = 3'd2,
    OP_JCNT = 3'd3,
    OP_CRST = 3'd4,
    OP_CINC = 3'd5,
    OP_CDEC = 3'd6,
    OP_NONE = 3'd7
  } brOp_e;

  typedef enum logic [1:0] {
    TGT_REG = 2'd0,
    TGT_IMM = 2'd1,
    TGT_REL = 2'd2
  } tgtSel_e;

  // comparator results produced by the datapath
  typedef struct packed {
    logic r0Eq;
    logic r0Lt;
    logic r0Gt;
    logic cntLt;
    logic cntEq;
  } brCmp_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    update;
    logic    take;
    tgtSel_e tgtSel;
    logic    cntClr;
    logic    cntInc;
    logic    cntDec;
  } brCtl_t;

endpackage

// File: rtl/branch_ctrl.sv
module branch_ctrl
  import branch_pkg::*;
(
  input  logic       opValid,
  input  logic [2:0] opKind,
  input  logic [2:0] opCond,
  input  logic       aluZero,
  input  logic       aluOverflow,
  input  brCmp_t     cmp,
  output brCtl_t     ctl
);

  brOp_e kind;
  logic  absHit;
  logic  r0Hit;
  logic  cntHit;

  assign kind = brOp_e'(opKind);

  always_comb begin
    case (opCond)
      3'd0:    absHit = 1'b1;
      3'd1:    absHit = aluZero;
      3'd2:    absHit = aluOverflow;
      default: absHit = 1'b0;
    endcase
    case (opCond)
      3'd0:    r0Hit = cmp.r0Eq;
      3'd1:    r0Hit = cmp.r0Lt;
      3'd2:    r0Hit = cmp.r0Gt;
      default: r0Hit = 1'b0;
    endcase
    case (opCond)
      3'd0:    cntHit = cmp.cntLt;
      3'd1:    cntHit = cmp.cntLt | cmp.cntEq;
      3'd2:    cntHit = ~cmp.cntLt;
      default: cntHit = 1'b0;
    endcase
  end

  always_comb begin
    ctl        = '0;
    ctl.tgtSel = TGT_REG;
    ctl.update = opValid;
    if (opValid) begin
      case (kind)
        OP_JREG: begin ctl.tgtSel = TGT_REG; ctl.take = absHit; end
        OP_JIMM: begin ctl.tgtSel = TGT_IMM; ctl.take = absHit; end
        OP_JR0:  begin ctl.tgtSel = TGT_REL; ctl.take = r0Hit;  end
        OP_JCNT: begin ctl.tgtSel = TGT_REL; ctl.take = cntHit; end
        OP_CRST: ctl.cntClr = 1'b1;
        OP_CINC: ctl.cntInc = 1'b1;
        OP_CDEC: ctl.cntDec = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/branch_dp.sv
module branch_dp
  import branch_pkg::*;
#(
  parameter int PC_W   = 11,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8,
  parameter int STEP_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  brCtl_t            ctl,
  input  logic [PC_W+1:0]   immAddr,
  input  logic [STEP_W-1:0] relStep,
  input  logic [DATA_W-1:0] threshold,
  input  logic [CNT_W-1:0]  cntImm,
  input  logic [PC_W-1:0]   curPc,
  input  logic [DATA_W-1:0] r0Val,
  input  logic [DATA_W-1:0] regTarget,
  output brCmp_t            cmp,
  output logic [PC_W-1:0]   nextPc,
  output logic              taken,
  output logic [CNT_W-1:0]  stageCnt
);

  localparam int SW = STEP_W - 2;

  logic [SW-1:0]   stepWords;
  logic [PC_W-1:0] relOff;
  logic [PC_W-1:0] target;
  logic [PC_W-1:0] seqPc;
  logic [CNT_W-1:0] cntThr;
  logic unusedBits;

  assign stepWords = relStep[STEP_W-1:2];
  assign cntThr    = threshold[CNT_W-1:0];

  generate
    if (SW >= PC_W) begin : g_stepTrunc
      assign relOff = stepWords[PC_W-1:0];
    end else begin : g_stepExt
      assign relOff = {{(PC_W-SW){stepWords[SW-1]}}, stepWords};
    end
  endgenerate

  assign unusedBits = ^{immAddr[1:0], relStep[1:0], regTarget, threshold};

  assign cmp.r0Eq  = (r0Val == threshold);
  assign cmp.r0Lt  = (r0Val <  threshold);
  assign cmp.r0Gt  = (r0Val >  threshold);
  assign cmp.cntLt = (stageCnt <  cntThr);
  assign cmp.cntEq = (stageCnt == cntThr);

  assign seqPc = curPc + PC_W'(1);

  always_comb begin
    case (ctl.tgtSel)
      TGT_REG: target = regTarget[PC_W-1:0];
      TGT_IMM: target = immAddr[PC_W+1:2];
      default: target = curPc + relOff;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageCnt <= '0;
    end else if (ctl.cntClr) begin
      stageCnt <= '0;
    end else if (ctl.cntInc) begin
      stageCnt <= stageCnt + cntImm;
    end else if (ctl.cntDec) begin
      stageCnt <= stageCnt - cntImm;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nextPc <= '0;
      taken  <= 1'b0;
    end else if (ctl.update) begin
      nextPc <= ctl.take ? target : seqPc;
      taken  <= ctl.take;
    end else begin
      taken  <= 1'b0;
    end
  end

endmodule

// File: rtl/branch_unit.sv
module branch_unit
  import branch_pkg::*;
#(
  parameter int PC_W   = 11,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8,
  parameter int STEP_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opKind,
  input  logic [2:0]        opCond,
  input  logic [PC_W+1:0]   immAddr,
  input  logic [STEP_W-1:0] relStep,
  input  logic [DATA_W-1:0] threshold,
  input  logic [CNT_W-1:0]  cntImm,
  input  logic [PC_W-1:0]   curPc,
  input  logic [DATA_W-1:0] r0Val,
  input  logic [DATA_W-1:0] regTarget,
  input  logic              aluZero,
  input  logic              aluOverflow,
  output logic [PC_W-1:0]   nextPc,
  output logic              taken,
  output logic [CNT_W-1:0]  stageCnt
);

  brCtl_t ctl;
  brCmp_t cmp;

  branch_ctrl u_ctrl (
    .opValid     (opValid),
    .opKind      (opKind),
    .opCond      (opCond),
    .aluZero     (aluZero),
    .aluOverflow (aluOverflow),
    .cmp         (cmp),
    .ctl         (ctl)
  );

  branch_dp #(
    .PC_W   (PC_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .STEP_W (STEP_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .immAddr   (immAddr),
    .relStep   (relStep),
    .threshold (threshold),
    .cntImm    (cntImm),
    .curPc     (curPc),
    .r0Val     (r0Val),
    .regTarget (regTarget),
    .cmp       (cmp),
    .nextPc    (nextPc),
    .taken     (taken),
    .stageCnt  (stageCnt)
  );

endmodule

// File: rtl/branch_unit_chk.sv
module branch_unit_chk
  import branch_pkg::*;
#(
  parameter int PC_W   = 11,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [2:0]        opKind,
  input logic [2:0]        opCond,
  input logic [PC_W+1:0]   immAddr,
  input logic [CNT_W-1:0]  cntImm,
  input logic [PC_W-1:0]   curPc,
  input logic [DATA_W-1:0] regTarget,
  input logic [PC_W-1:0]   nextPc,
  input logic              taken,
  input logic [CNT_W-1:0]  stageCnt
);

  logic isCntOp;
  assign isCntOp = opValid && (opKind == OP_CRST || opKind == OP_CINC ||
                               opKind == OP_CDEC || opKind == OP_NONE);

  p_cnt_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opKind == OP_CRST) |=> (stageCnt == '0));

  p_cnt_add_r2: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opKind == OP_CINC) |=> (stageCnt == CNT_W'($past(stageCnt) + $past(cntImm))));

  p_cnt_sub_r2: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opKind == OP_CDEC) |=> (stageCnt == CNT_W'($past(stageCnt) - $past(cntImm))));

  p_reg_jump_r3: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opKind == OP_JREG && opCond == 3'd0) |=>
      (taken && nextPc == $past(regTarget[PC_W-1:0])));

  p_imm_jump_r4: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opKind == OP_JIMM && opCond == 3'd0) |=>
      (taken && nextPc == $past(immAddr[PC_W+1:2])));

  p_seq_after_cnt_op_r9: assert property (@(posedge clk) disable iff (!rstN)
    isCntOp |=> (!taken && nextPc == PC_W'($past(curPc) + 1)));

  p_none_keeps_cnt_r9: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opKind == OP_NONE) |=> $stable(stageCnt));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> (!taken && $stable(stageCnt) && $stable(nextPc)));

endmodule

bind branch_unit branch_unit_chk #(
  .PC_W   (PC_W),
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .opValid   (opValid),
  .opKind    (opKind),
  .opCond    (opCond),
  .immAddr   (immAddr),
  .cntImm    (cntImm),
  .curPc     (curPc),
  .regTarget (regTarget),
  .nextPc    (nextPc),
  .taken     (taken),
  .stageCnt  (stageCnt)
);

// File: tb/tb_branch_unit.sv
module tb_branch_unit;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opKind = '0;
  logic [2:0]  opCond = '0;
  logic [12:0] immAddr = '0;
  logic [13:0] relStep = '0;
  logic [15:0] threshold = '0;
  logic [7:0]  cntImm = '0;
  logic [10:0] curPc = '0;
  logic [15:0] r0Val = '0;
  logic [15:0] regTarget = '0;
  logic        aluZero = 1'b0;
  logic        aluOverflow = 1'b0;
  logic [10:0] nextPc;
  logic        taken;
  logic [7:0]  stageCnt;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_unit dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opKind(opKind), .opCond(opCond),
    .immAddr(immAddr), .relStep(relStep), .threshold(threshold), .cntImm(cntImm),
    .curPc(curPc), .r0Val(r0Val), .regTarget(regTarget), .aluZero(aluZero),
    .aluOverflow(aluOverflow), .nextPc(nextPc), .taken(taken), .stageCnt(stageCnt)
  );

  typedef struct packed {
    logic [2:0]  kind;
    logic [2:0]  cond;
    logic [12:0] imm;
    logic [13:0] step;
    logic [15:0] thr;
    logic [10:0] pc;
    logic [15:0] r0;
    logic [15:0] rtgt;
    logic        z;
    logic        ov;
    logic        expT;
    logic [10:0] expPc;
    logic [3:0]  req;
  } vec_t;

  // kind cond imm step thr pc r0 rtgt z ov expT expPc req
  localparam vec_t VEC [NVEC] = '{
    '{3'd0, 3'd0, 13'h0000, 14'd0,    16'd0,   11'd5,     16'd0,     16'hF123, 1'b0, 1'b0, 1'b1, 11'h123, 4'd3}, // R3
    '{3'd1, 3'd0, 13'h0120, 14'd0,    16'd0,   11'd5,     16'd0,     16'd0,    1'b0, 1'b0, 1'b1, 11'h048, 4'd4}, // R4
    '{3'd1, 3'd0, 13'h1FFC, 14'd0,    16'd0,   11'd5,     16'd0,     16'd0,    1'b0, 1'b0, 1'b1, 11'h7FF, 4'd4}, // R4
    '{3'd0, 3'd1, 13'h0000, 14'd0,    16'd0,   11'd7,     16'd0,     16'h0040, 1'b1, 1'b0, 1'b1, 11'h040, 4'd5}, // R5
    '{3'd0, 3'd1, 13'h0000, 14'd0,    16'd0,   11'h010,   16'd0,     16'h0040, 1'b0, 1'b1, 1'b0, 11'h011, 4'd5}, // R5
    '{3'd1, 3'd2, 13'h0100, 14'd0,    16'd0,   11'd7,     16'd0,     16'd0,    1'b0, 1'b1, 1'b1, 11'h040, 4'd5}, // R5
    '{3'd1, 3'd2, 13'h0100, 14'd0,    16'd0,   11'h7FF,   16'd0,     16'd0,    1'b1, 1'b0, 1'b0, 11'h000, 4'd9}, // R9 wrap
    '{3'd0, 3'd3, 13'h0000, 14'd0,    16'd0,   11'd3,     16'd0,     16'h0040, 1'b1, 1'b1, 1'b0, 11'd4,   4'd5}, // R5
    '{3'd2, 3'd0, 13'h0000, 14'd16,   16'd20,  11'd100,   16'd20,    16'd0,    1'b0, 1'b0, 1'b1, 11'd104, 4'd6}, // R6
    '{3'd2, 3'd0, 13'h0000, 14'd16,   16'd20,  11'd100,   16'd21,    16'd0,    1'b0, 1'b0, 1'b0, 11'd101, 4'd6}, // R6
    '{3'd2, 3'd1, 13'h0000, 14'h3FF8, 16'd20,  11'd100,   16'd19,    16'd0,    1'b0, 1'b0, 1'b1, 11'd98,  4'd8}, // R8
    '{3'd2, 3'd1, 13'h0000, 14'd16,   16'd1,   11'd100,   16'h8000,  16'd0,    1'b0, 1'b0, 1'b0, 11'd101, 4'd6}, // R6 unsigned
    '{3'd2, 3'd2, 13'h0000, 14'd12,   16'd1,   11'd100,   16'h8000,  16'd0,    1'b0, 1'b0, 1'b1, 11'd103, 4'd6}, // R6
    '{3'd2, 3'd2, 13'h0000, 14'd12,   16'd5,   11'd100,   16'd5,     16'd0,    1'b0, 1'b0, 1'b0, 11'd101, 4'd6}, // R6
    '{3'd2, 3'd3, 13'h0000, 14'd12,   16'd5,   11'd100,   16'd5,     16'd0,    1'b1, 1'b1, 1'b0, 11'd101, 4'd6}, // R6
    '{3'd2, 3'd0, 13'h0000, 14'h3FF0, 16'd0,   11'd2,     16'd0,     16'd0,    1'b0, 1'b0, 1'b1, 11'h7FE, 4'd8}, // R8 wrap down
    '{3'd2, 3'd0, 13'h0000, 14'h1FFC, 16'd0,   11'h7F0,   16'd0,     16'd0,    1'b0, 1'b0, 1'b1, 11'h7EF, 4'd8}, // R8 wrap up
    '{3'd7, 3'd0, 13'h0000, 14'd0,    16'd0,   11'd9,     16'd0,     16'd0,    1'b1, 1'b1, 1'b0, 11'd10,  4'd9}  // R9
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse();
    opValid = 1'b1;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  task automatic setOp(input logic [2:0] k, input logic [2:0] c, input logic [10:0] pc);
    opKind = k;
    opCond = c;
    curPc  = pc;
  endtask

  task automatic cntOp(input logic [2:0] k, input logic [7:0] amt);
    setOp(k, 3'd0, 11'd30);
    cntImm = amt;
    pulse();
  endtask

  task automatic cntBranch(input logic [2:0] c, input logic [7:0] thr, input logic expT,
                           input string req);
    setOp(3'd3, c, 11'd50);
    threshold = {8'hFF, thr};
    relStep = 14'd40;
    pulse();
    chk(req, {31'd0, taken}, {31'd0, expT});
    chk(req, {21'd0, nextPc}, expT ? 32'd60 : 32'd51);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [10:0] heldPc;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", {21'd0, nextPc}, 32'd0);
    chk("R1", {31'd0, taken}, 32'd0);
    chk("R1", {24'd0, stageCnt}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // table of stateless branch vectors
    for (int i = 0; i < NVEC; i++) begin
      setOp(VEC[i].kind, VEC[i].cond, VEC[i].pc);
      immAddr = VEC[i].imm;  relStep = VEC[i].step;  threshold = VEC[i].thr;
      r0Val = VEC[i].r0;  regTarget = VEC[i].rtgt;
      aluZero = VEC[i].z;  aluOverflow = VEC[i].ov;
      pulse();
      chk($sformatf("R%0d vec%0d taken", VEC[i].req, i), {31'd0, taken}, {31'd0, VEC[i].expT});
      chk($sformatf("R%0d vec%0d pc", VEC[i].req, i), {21'd0, nextPc}, {21'd0, VEC[i].expPc});
    end

    // R2: counter arithmetic with wrap
    cntOp(3'd4, 8'd0);   chk("R2 clear", {24'd0, stageCnt}, 32'd0);
    cntOp(3'd5, 8'd10);  chk("R2 add", {24'd0, stageCnt}, 32'd10);
    cntOp(3'd6, 8'd3);   chk("R2 sub", {24'd0, stageCnt}, 32'd7);
    cntOp(3'd6, 8'd8);   chk("R2 sub wrap", {24'd0, stageCnt}, 32'd255);
    cntOp(3'd5, 8'd2);   chk("R2 add wrap", {24'd0, stageCnt}, 32'd1);
    // R9: counter op is sequential, not taken
    chk("R9 cnt op taken", {31'd0, taken}, 32'd0);
    chk("R9 cnt op pc", {21'd0, nextPc}, 32'd31);
    cntOp(3'd7, 8'd9);   chk("R9 none keeps cnt", {24'd0, stageCnt}, 32'd1);

    // R7: counter-relative compares at count 1
    cntBranch(3'd0, 8'd2, 1'b1, "R7 LT below");
    cntBranch(3'd0, 8'd1, 1'b0, "R7 LT equal");
    cntBranch(3'd1, 8'd1, 1'b1, "R7 LE equal");
    cntBranch(3'd1, 8'd0, 1'b0, "R7 LE above");
    cntBranch(3'd2, 8'd1, 1'b1, "R7 GE equal");
    cntBranch(3'd2, 8'd2, 1'b0, "R7 GE below");
    cntBranch(3'd3, 8'd1, 1'b0, "R7 reserved cond");
    // counter at 255 after wrap: GE 200 taken
    cntOp(3'd6, 8'd2);
    cntBranch(3'd2, 8'd200, 1'b1, "R7 after wrap");

    // R10: idle cycle holds state even with a counter op on the inputs
    heldPc = nextPc;
    opKind = 3'd5; cntImm = 8'd4; opValid = 1'b0;
    @(negedge clk);
    chk("R10 idle taken", {31'd0, taken}, 32'd0);
    chk("R10 idle pc", {21'd0, nextPc}, {21'd0, heldPc});
    chk("R10 idle cnt", {24'd0, stageCnt}, 32'd255);

    // R11: counter-equal composite, count=5
    cntOp(3'd4, 8'd0);
    cntOp(3'd5, 8'd5);
    for (int t = 4; t <= 6; t++) begin
      logic [10:0] finalPc;
      threshold = 16'(t);
      setOp(3'd3, 3'd0, 11'd20); relStep = 14'd8; pulse();   // skip if LT
      if (taken) finalPc = nextPc;
      else begin
        setOp(3'd3, 3'd1, 11'd21); relStep = 14'd36; pulse(); // branch if LE
        finalPc = nextPc;
      end
      chk($sformatf("R11 cnt EQ thr=%0d", t), {21'd0, finalPc}, (t == 5) ? 32'd30 : (t == 4 ? 32'd22 : 32'd22));
    end
    // R11: R0 greater-or-equal composite (EQ then GT)
    for (int v = 9; v <= 11; v++) begin
      logic [10:0] finalPc;
      r0Val = 16'(v); threshold = 16'd10;
      setOp(3'd2, 3'd0, 11'd40); relStep = 14'd40; pulse();
      if (taken) finalPc = nextPc;
      else begin
        setOp(3'd2, 3'd2, 11'd41); relStep = 14'd36; pulse();
        finalPc = nextPc;
      end
      chk($sformatf("R11 r0 GE v=%0d", v), {21'd0, finalPc}, (v >= 10) ? 32'd50 : 32'd42);
    end

    // R1: reset mid-run
    rstN = 1'b0;
    @(negedge clk);
    chk("R1 mid reset cnt", {24'd0, stageCnt}, 32'd0);
    chk("R1 mid reset pc", {21'd0, nextPc}, 32'd0);
    chk("R1 mid reset taken", {31'd0, taken}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule